// File: doc/BRIEF.md
# ADC Control-Register Power-Up Configurator

This block sits on the host side of a parallel-bus data converter that holds two 10-bit control registers. After power-up, a single start pulse makes it walk the converter through its configuration. First it writes a fixed pair of words that pulse the converter's device-reset bit. Then it either stops, when the converter's built-in defaults are wanted, or writes the user's value for register 0 followed by the user's value for register 1. The register 1 word carries bit 10 set, which steers the write to that register. When the register 0 value selects more than one converted channel, the block forces the channel-1 marker reset bit into the register 1 write, so that the converter's channel-1 marker lines up with the scan order.

Every write is a self-timed bus cycle. The active-low chip select and the data word are presented for a set number of setup cycles. Then the active-low write strobe is driven for a set number of cycles. The select and data then stay put for a set number of hold cycles. A one-cycle done flag closes the sequence. The configuration inputs are captured on the accepted start pulse. Starts and input changes that arrive while a sequence runs have no effect.

Top module: `adc_cfg_seq`

## Requirements
- R1: While rst_n is low and after its release, with no start, bus_cs_n = 1, bus_wr_n = 1, bus_data = 0 and cfg_done = 0.
- R2: A start pulse accepted while idle produces a first bus write of 0x401 and a second of 0x400. Bit 10 addresses register 1 and bit 0 is the device-reset bit.
- R3: With use_defaults = 1 captured at start, exactly two writes occur (the pair in R2) and then the sequence ends.
- R4: With use_defaults = 0, the third write is the captured user_cr0 value with bit 10 and all bits above it zero.
- R5: With use_defaults = 0, the fourth and last write is 0x400 OR the captured user_cr1, with bit 0 forced to 0.
- R6: Bit 1 of the fourth write is forced to 1 when captured user_cr0 has bit 7 (scan) = 1 and bits 4:3 (channel select) nonzero. Otherwise it equals user_cr1 bit 1.
- R7: In each write, bus_cs_n is low and bus_data is stable for SETUP_CYC cycles before bus_wr_n falls. bus_wr_n is then low for WR_CYC cycles. bus_cs_n stays low for HOLD_CYC cycles after bus_wr_n rises. bus_wr_n is never low while bus_cs_n is high.
- R8: Between two consecutive writes of one sequence, bus_cs_n is high for exactly 2 cycles.
- R9: cfg_done is high for exactly one cycle: the second cycle that bus_cs_n is high after the final write.
- R10: Start pulses, and changes on use_defaults, user_cr0 and user_cr1, that occur after a sequence is accepted and before its cfg_done have no effect on that sequence's writes or count.
- R11: bus_data is 0 whenever bus_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a configuration sequence (honoured only when idle) |
| use_defaults | input | 1 | 1: stop after the reset pair |
| user_cr0 | input | 10 | Value for control register 0 |
| user_cr1 | input | 10 | Value for control register 1 |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_data | output | BUS_W (12) | Write data bus |
| cfg_done | output | 1 | One-cycle end-of-sequence flag |

## Verification
The start pulse is registered, so bus_cs_n falls on the second cycle after the cycle in which start is high. The setup, strobe and hold phases then last SETUP_CYC, WR_CYC and HOLD_CYC cycles. bus_cs_n stays high for two cycles between writes, and cfg_done appears in the second of those high cycles after the last write. The bench monitors the bus on the falling clock edge. It measures each phase length, the gap and the done lag as cycle counts against those numbers, so its checks are tied to the cycle counts rather than to absolute times. After each cfg_done it watches a further dozen cycles, to confirm that no extra write appears.

// File: rtl/adc_cfg_pkg.sv
// Package: shared constants and state types for the ADC configuration sequencer.
// Assumes the converter's control registers are 10 bits wide and that bit 10
// of a bus word selects register 1.
package adc_cfg_pkg;
    localparam int REG_W        = 10;
    localparam int SEL_BIT      = 10;  // bus word bit that addresses register 1
    localparam int DEV_RST_BIT  = 0;   // register 1 device reset
    localparam int SYNC_RST_BIT = 1;   // register 1 channel-1 marker reset
    localparam int SCAN_BIT     = 7;   // register 0 scan enable
    localparam int CHSEL_LO     = 3;   // register 0 channel select, low bit
    localparam int CHSEL_HI     = 4;   // register 0 channel select, high bit
    localparam int STEP_W       = 2;

    typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_state_t;
    typedef enum logic [1:0] {WE_IDLE, WE_SETUP, WE_STROBE, WE_HOLD} wr_state_t;
endpackage

// File: rtl/adc_cfg_chan.sv
// Module: decodes the channel count selected by a register 0 value.
// Assumes the channel count is the select field plus one when scan is on, else one.
module adc_cfg_chan
    import adc_cfg_pkg::*;
(
    input  logic [REG_W-1:0] cr0,
    output logic [2:0]       chan_cnt,
    output logic             multi
);
    localparam int SEL_W = CHSEL_HI - CHSEL_LO + 1;

    logic [SEL_W-1:0] sel;

    // Derive the number of converted channels and the multichannel flag.
    always_comb begin
        sel      = cr0[CHSEL_HI:CHSEL_LO];
        chan_cnt = cr0[SCAN_BIT] ? (3'(sel) + 3'd1) : 3'd1;
        multi    = (chan_cnt > 3'd1);
    end
endmodule

// File: rtl/adc_cfg_word.sv
// Module: builds the bus word for each step of the configuration sequence.
// Steps: 0 reset set, 1 reset clear, 2 register 0, 3 register 1.
// Assumes BUS_W > SEL_BIT; bits above the select bit stay zero.
module adc_cfg_word
    import adc_cfg_pkg::*;
#(
    parameter int BUS_W = 12
) (
    input  logic [STEP_W-1:0] step,
    input  logic              use_def,
    input  logic [REG_W-1:0]  cr0,
    input  logic [REG_W-1:0]  cr1,
    input  logic              multi,
    output logic [BUS_W-1:0]  word,
    output logic              last
);
    logic [REG_W-1:0] cr1_fix;

    // Register 1 user value with device reset cleared and the marker reset forced when needed.
    always_comb begin
        cr1_fix               = cr1;
        cr1_fix[DEV_RST_BIT]  = 1'b0;
        cr1_fix[SYNC_RST_BIT] = cr1[SYNC_RST_BIT] | multi;
    end

    // Select the word for the current step and flag the final step.
    always_comb begin
        word = '0;
        case (step)
            2'd0: begin
                word[SEL_BIT]     = 1'b1;
                word[DEV_RST_BIT] = 1'b1;
            end
            2'd1: word[SEL_BIT] = 1'b1;
            2'd2: word[REG_W-1:0] = cr0;
            default: begin
                word[REG_W-1:0] = cr1_fix;
                word[SEL_BIT]   = 1'b1;
            end
        endcase
        last = (step == 2'd3) || (use_def && step == 2'd1);
    end
endmodule

// File: rtl/adc_cfg_wr_engine.sv
// Module: runs one timed bus write (setup, strobe, hold) per request.
// Assumes req is only raised while busy is low and all phase counts are >= 1.
// Outputs are registered; wr_done pulses in the cycle chip select returns high.
module adc_cfg_wr_engine
    import adc_cfg_pkg::*;
#(
    parameter int BUS_W     = 12,
    parameter int SETUP_CYC = 2,
    parameter int WR_CYC    = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [BUS_W-1:0] word,
    output logic             busy,
    output logic             wr_done,
    output logic             cs_n,
    output logic             wr_n,
    output logic [BUS_W-1:0] data
);
    localparam int MAX_AB = (SETUP_CYC > WR_CYC) ? SETUP_CYC : WR_CYC;
    localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
    localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    wr_state_t  st;
    logic [CNT_W-1:0] cnt;

    // Phase sequencing with a down-counter per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= WE_IDLE;
            cnt     <= '0;
            cs_n    <= 1'b1;
            wr_n    <= 1'b1;
            data    <= '0;
            wr_done <= 1'b0;
        end else begin
            wr_done <= 1'b0;
            case (st)
                WE_IDLE: if (req) begin
                    st   <= WE_SETUP;
                    cs_n <= 1'b0;
                    data <= word;
                    cnt  <= CNT_W'(SETUP_CYC - 1);
                end
                WE_SETUP: if (cnt == '0) begin
                    st   <= WE_STROBE;
                    wr_n <= 1'b0;
                    cnt  <= CNT_W'(WR_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                WE_STROBE: if (cnt == '0) begin
                    st   <= WE_HOLD;
                    wr_n <= 1'b1;
                    cnt  <= CNT_W'(HOLD_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (cnt == '0) begin
                    st      <= WE_IDLE;
                    cs_n    <= 1'b1;
                    data    <= '0;
                    wr_done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Busy whenever a write is in flight.
    always_comb busy = (st != WE_IDLE);
endmodule

// File: rtl/adc_cfg_seq.sv
// Module: top of the ADC configuration sequencer. On start it captures the
// configuration, then issues reset-set, reset-clear and, unless defaults are
// requested, register 0 and register 1 writes, and pulses cfg_done.
// Assumes start is ignored while a sequence runs; BUS_W must exceed SEL_BIT.
module adc_cfg_seq
    import adc_cfg_pkg::*;
#(
    parameter int BUS_W     = 12,
    parameter int SETUP_CYC = 2,
    parameter int WR_CYC    = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             use_defaults,
    input  logic [9:0]       user_cr0,
    input  logic [9:0]       user_cr1,
    output logic             bus_cs_n,
    output logic             bus_wr_n,
    output logic [BUS_W-1:0] bus_data,
    output logic             cfg_done
);
    seq_state_t        st;
    logic [STEP_W-1:0] step;
    logic              cap_def;
    logic [REG_W-1:0]  cap_cr0;
    logic [REG_W-1:0]  cap_cr1;
    logic              req;
    logic              busy;
    logic              wr_done;
    logic [BUS_W-1:0]  word;
    logic              last;
    logic              multi;
    logic [2:0]        chan_cnt;

    // Decode multichannel operation from the captured register 0 value.
    adc_cfg_chan u_chan (
        .cr0      (cap_cr0),
        .chan_cnt (chan_cnt),
        .multi    (multi)
    );

    // Form the word for the current step.
    adc_cfg_word #(.BUS_W(BUS_W)) u_word (
        .step    (step),
        .use_def (cap_def),
        .cr0     (cap_cr0),
        .cr1     (cap_cr1),
        .multi   (multi),
        .word    (word),
        .last    (last)
    );

    // Perform the timed bus write.
    adc_cfg_wr_engine #(
        .BUS_W     (BUS_W),
        .SETUP_CYC (SETUP_CYC),
        .WR_CYC    (WR_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .word    (word),
        .busy    (busy),
        .wr_done (wr_done),
        .cs_n    (bus_cs_n),
        .wr_n    (bus_wr_n),
        .data    (bus_data)
    );

    // Request a write only in the issue state with the engine free.
    always_comb req = (st == SQ_ISSUE) && !busy;

    // Step through the sequence and capture configuration on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_IDLE;
            step     <= '0;
            cap_def  <= 1'b0;
            cap_cr0  <= '0;
            cap_cr1  <= '0;
            cfg_done <= 1'b0;
        end else begin
            cfg_done <= 1'b0;
            case (st)
                SQ_IDLE: if (start) begin
                    cap_def <= use_defaults;
                    cap_cr0 <= user_cr0;
                    cap_cr1 <= user_cr1;
                    step    <= '0;
                    st      <= SQ_ISSUE;
                end
                SQ_ISSUE: if (req) st <= SQ_WAIT;
                default: if (wr_done) begin
                    if (last) begin
                        st       <= SQ_IDLE;
                        cfg_done <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                        st   <= SQ_ISSUE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_cfg_seq_chk.sv
// Module: protocol checker for the configuration sequencer's bus and done flag.
// Assumes it is bound to adc_cfg_seq and sees its ports only.
module adc_cfg_seq_chk #(
    parameter int BUS_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             wr_n,
    input logic [BUS_W-1:0] data,
    input logic             done
);
    // R7: strobe only inside chip select.
    a_r7_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n);

    // R7: strobe falls only after at least one setup cycle.
    a_r7_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(!cs_n));

    // R7: data steady while selected.
    a_r7_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(data));

    // R11: bus idles at zero.
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (data == '0));

    // R8: select high at least two cycles once released.
    a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    // R9: done is a single-cycle pulse.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done lands in the second high cycle after a write.
    a_r9_done_place: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(cs_n) && !$past(cs_n, 2)));
endmodule

bind adc_cfg_seq adc_cfg_seq_chk #(.BUS_W(BUS_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (bus_cs_n),
    .wr_n  (bus_wr_n),
    .data  (bus_data),
    .done  (cfg_done)
);

// File: tb/adc_cfg_seq_test.sv
module adc_cfg_seq_test;
    localparam int BUS_W = 12;
    localparam int SU    = 2;
    localparam int PL    = 3;
    localparam int HD    = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             use_defaults = 1'b0;
    logic [9:0]       user_cr0 = '0;
    logic [9:0]       user_cr1 = '0;
    logic             bus_cs_n;
    logic             bus_wr_n;
    logic [BUS_W-1:0] bus_data;
    logic             cfg_done;

    int checks = 0;
    int errors = 0;

    // monitor state
    int cyc = 0;
    int nw = 0;
    logic [BUS_W-1:0] wdat [8];
    int su_c [8];
    int pl_c [8];
    int hd_c [8];
    int unstable = 0;
    int gap_bad = 0;
    int done_cnt = 0;
    int done_lag = 0;
    int last_rise = 0;
    int hi_run = 0;
    int phase = 0;
    logic prev_cs = 1'b1;
    logic [BUS_W-1:0] first_d = '0;

    always #2 clk = ~clk;

    adc_cfg_seq #(.BUS_W(BUS_W), .SETUP_CYC(SU), .WR_CYC(PL), .HOLD_CYC(HD)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .use_defaults(use_defaults),
        .user_cr0(user_cr0), .user_cr1(user_cr1), .bus_cs_n(bus_cs_n),
        .bus_wr_n(bus_wr_n), .bus_data(bus_data), .cfg_done(cfg_done)
    );

    // Bus monitor sampled on the falling edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (!bus_cs_n) begin
                if (prev_cs) begin
                    if (nw > 0 && hi_run != 2) gap_bad = gap_bad + 1;
                    if (nw < 8) begin su_c[nw] = 0; pl_c[nw] = 0; hd_c[nw] = 0; end
                    phase = 0;
                    first_d = bus_data;
                end
                if (bus_data != first_d) unstable = unstable + 1;
                if (nw < 8) begin
                    if (bus_wr_n && phase == 0) su_c[nw] = su_c[nw] + 1;
                    else if (!bus_wr_n) begin
                        phase = 1;
                        pl_c[nw] = pl_c[nw] + 1;
                        wdat[nw] = bus_data;
                    end else hd_c[nw] = hd_c[nw] + 1;
                end
                hi_run = 0;
            end else begin
                if (!prev_cs) begin
                    nw = nw + 1;
                    last_rise = cyc;
                    hi_run = 1;
                end else hi_run = hi_run + 1;
                if (bus_data != '0) unstable = unstable + 1;
            end
            if (cfg_done) begin
                done_cnt = done_cnt + 1;
                done_lag = cyc - last_rise;
            end
            prev_cs = bus_cs_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_seq(input bit def, input logic [9:0] c0, input logic [9:0] c1, input bit poke);
        logic [BUS_W-1:0] exp_w [4];
        int exp_n;
        bit multi;
        bit seen;
        @(posedge clk); #1;
        nw = 0; done_cnt = 0; unstable = 0; gap_bad = 0; done_lag = 0;
        use_defaults = def; user_cr0 = c0; user_cr1 = c1; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        // R10: scramble inputs after acceptance
        use_defaults = ~def; user_cr0 = ~c0; user_cr1 = ~c1;
        if (poke) begin
            repeat (6) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        seen = 0;
        for (int k = 0; k < 300 && !seen; k++) begin
            @(negedge clk);
            if (cfg_done) seen = 1;
        end
        repeat (12) @(negedge clk);
        multi = c0[7] && (c0[4:3] != 2'b00);
        exp_w[0] = 12'h401;
        exp_w[1] = 12'h400;
        exp_w[2] = {2'b00, c0};
        exp_w[3] = 12'h400 | {2'b00, c1 & 10'h3FE} | (multi ? 12'h002 : 12'h000);
        exp_n = def ? 2 : 4;
        check(nw == exp_n, def ? "R3 write count" : "R10 write count", nw, exp_n);
        for (int i = 0; i < exp_n && i < nw; i++) begin
            if (i < 2) check(wdat[i] == exp_w[i], "R2 reset pair word", wdat[i], exp_w[i]);
            else if (i == 2) check(wdat[i] == exp_w[i], "R4 register 0 word", wdat[i], exp_w[i]);
            else begin
                check(wdat[i] == exp_w[i], "R5 register 1 word", wdat[i], exp_w[i]);
                check(wdat[i][1] == exp_w[i][1], "R6 marker reset bit", wdat[i][1], exp_w[i][1]);
            end
            check(su_c[i] == SU, "R7 setup cycles", su_c[i], SU);
            check(pl_c[i] == PL, "R7 strobe cycles", pl_c[i], PL);
            check(hd_c[i] == HD, "R7 hold cycles", hd_c[i], HD);
        end
        check(unstable == 0, "R11 data stable/idle zero", unstable, 0);
        check(gap_bad == 0, "R8 gap of two cycles", gap_bad, 0);
        check(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
        check(done_lag == 1, "R9 done placement", done_lag, 1);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_cs_n === 1'b1 && bus_wr_n === 1'b1, "R1 reset strobes", {bus_cs_n, bus_wr_n}, 3);
        check(bus_data === '0 && cfg_done === 1'b0, "R1 reset data/done", bus_data, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(bus_cs_n === 1'b1 && bus_wr_n === 1'b1 && bus_data == '0 && !cfg_done,
              "R1 idle after reset", bus_data, 0);
        // Defaults path
        run_seq(1'b1, 10'h090, 10'h0C0, 1'b0);
        run_seq(1'b1, 10'h3FF, 10'h3FF, 1'b1);
        // Named corner cases
        run_seq(1'b0, 10'h090, 10'h0C0, 1'b0); // R6 multichannel forces bit 1
        run_seq(1'b0, 10'h080, 10'h003, 1'b0); // R6 scan with one channel: bit 1 from user, bit 0 cleared
        run_seq(1'b0, 10'h018, 10'h001, 1'b1); // R6 select without scan, R10 poke
        // Sweep over scan, diff and channel-select fields
        for (int s = 0; s < 2; s++)
            for (int df = 0; df < 4; df++)
                for (int ch = 0; ch < 4; ch++) begin
                    int i;
                    logic [9:0] c0;
                    logic [9:0] c1;
                    i  = s * 16 + df * 4 + ch;
                    c0 = 10'((s << 7) | (df << 5) | (ch << 3) | (i & 7) | ((i & 3) << 8));
                    c1 = 10'((i * 83 + 5) & 10'h3FF);
                    run_seq(1'b0, c0, c1, (i % 5) == 0);
                end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule